// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block sequences the start-up ramp, the shutdown ramp and the recovery after faults for a converter control loop. It keeps a digital soft-start level that climbs by a programmable step every clock cycle up to a programmable ceiling. While the loop is not in its steady run state, that level acts as an upper clamp on the error command on its way to the PWM generator.

Four shutdown sources are watched. The first is an external disable request. The second is a supply code compared against a start code and a lower stop code, which gives hysteresis. The third is a reference-ready flag. The fourth is an overcurrent compare. A supply undervoltage or a missing reference empties the level at once. The external disable also drops the level to zero. An overcurrent starts a soft stop: the level falls ten times faster than it rises until it is below the off threshold, and then a full soft start begins again from zero.

A separate peak-current compare limits individual PWM cycles without touching the sequence. The error command moves through the block as a valid/ready stream. It passes straight through in the same cycle, so valid travels forward and ready travels backward unchanged, and the data is held by nobody in between. A downstream stall therefore stalls the upstream source in the same cycle.

Top module: `ss_fault_seq`

## Requirements
- R1: After reset, state_code is 0 (sleep), ss_level is 0 and out_en is 0. The state codes are 0 sleep, 1 ramping, 2 running, 3 stopping and 4 held off.
- R2: Undervoltage is present when supply_code is below UV_STOP_CODE. Once present, it clears only when supply_code reaches UV_START_CODE or more. Between the two codes the previous condition is kept.
- R3: Undervoltage or ref_ok low takes priority over every other source. At the next clock edge the state becomes 0 and ss_level becomes 0, whatever the state was.
- R4: In state 1 or 2, oc_trip moves to state 3 and lowers ss_level by 10 × cfg_up_step, floored at 0. While in state 3, the level drops by the same amount each cycle while it is at or above OFF_LVL. When it is below OFF_LVL, the next edge gives state 1 with level 0.
- R5: From state 0 or 4, once the blocking source has cleared, the next edge gives state 1 with level 0. In state 1 or 2 without overcurrent, ss_level becomes min(level + cfg_up_step, cfg_max_lvl). It never wraps. The state is 2 exactly when the new level equals cfg_max_lvl.
- R6: cmd_out_data equals cmd_in_data in state 2. In every other state it equals min(cmd_in_data, ss_level).
- R7: ext_off high, with no undervoltage and ref_ok high, gives state 4 and level 0 at the next edge.
- R8: out_en is 1 exactly when ss_level > OFF_LVL, the state is 1 or 2, and no shutdown source is active in the same cycle.
- R9: cyc_limit equals peak_trip AND out_en. peak_trip never changes the state or the level.
- R10: cmd_out_valid equals cmd_in_valid and cmd_in_ready equals cmd_out_ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_off | input | 1 | External disable request |
| supply_code | input | SUP_W | Digitised supply level |
| ref_ok | input | 1 | Reference ready |
| oc_trip | input | 1 | Overcurrent compare result |
| peak_trip | input | 1 | Peak-current compare result |
| cfg_up_step | input | STEP_W | Ramp-up step per cycle |
| cfg_max_lvl | input | LVL_W | Ramp ceiling |
| cmd_in_valid | input | 1 | Error command valid |
| cmd_in_ready | output | 1 | Error command accepted |
| cmd_in_data | input | LVL_W | Error command |
| cmd_out_valid | output | 1 | Clamped command valid |
| cmd_out_ready | input | 1 | Downstream ready |
| cmd_out_data | output | LVL_W | Clamped command |
| ss_level | output | LVL_W | Soft-start level |
| out_en | output | 1 | Power stage enable |
| cyc_limit | output | 1 | Terminate current PWM cycle |
| state_code | output | 3 | Sequencer state |

## Verification
The case that needs the most care is an overcurrent that arrives in the same cycle as an undervoltage. Both would act on the level at the same edge, one by starting a soft stop and the other by emptying the level. The bench raises oc_trip and drops supply_code below the stop code on the same negative edge while the block is running. It then expects state 0 with level 0 after the next edge, with no pass through state 3. Peak-current pulses fall on every third cycle during ramps and soft stops, and they are judged by the level following the computed ramp exactly, unaffected by them.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_RAMP  = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_HOLD  = 3'd4
  } ss_state_e;
endpackage

// File: rtl/ss_uv_hyst.sv
module ss_uv_hyst #(
  parameter int SUP_W = 8,
  parameter int START_CODE = 176,
  parameter int STOP_CODE = 144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  output logic             uv_now
);
  localparam logic [SUP_W-1:0] START_V = SUP_W'(START_CODE);
  localparam logic [SUP_W-1:0] STOP_V  = SUP_W'(STOP_CODE);

  logic uv_q;

  // Below stop: fault. Inside the band: previous decision sticks.
  assign uv_now = (supply_code < STOP_V) || (uv_q && (supply_code < START_V));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 1'b1;
    else        uv_q <= uv_now;
  end
endmodule

// File: rtl/ss_level_fsm.sv
module ss_level_fsm
  import ss_seq_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int STEP_W = 4,
  parameter int OFF_LVL = 16,
  parameter int DOWN_MUL = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_now,
  input  logic              ref_ok,
  input  logic              ext_off,
  input  logic              oc_trip,
  input  logic [STEP_W-1:0] up_step,
  input  logic [LVL_W-1:0]  max_lvl,
  output ss_state_e         state,
  output logic [LVL_W-1:0]  level
);
  localparam int DN_W = STEP_W + $clog2(DOWN_MUL + 1);
  localparam int WW = ((LVL_W > DN_W) ? LVL_W : DN_W) + 1;
  localparam logic [LVL_W-1:0] OFF_V = LVL_W'(OFF_LVL);

  ss_state_e        st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [WW-1:0]    lvl_w, sum_w, dn_w;
  logic [LVL_W-1:0] up_nxt, dn_nxt;

  assign lvl_w  = WW'(lvl_q);
  assign sum_w  = lvl_w + WW'(up_step);
  assign dn_w   = WW'(up_step) * WW'(DOWN_MUL);
  assign up_nxt = (sum_w >= WW'(max_lvl)) ? max_lvl : sum_w[LVL_W-1:0];
  assign dn_nxt = (lvl_w > dn_w) ? LVL_W'(lvl_w - dn_w) : '0;

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    if (uv_now || !ref_ok) begin
      st_d  = ST_SLEEP;
      lvl_d = '0;
    end else if (ext_off) begin
      st_d  = ST_HOLD;
      lvl_d = '0;
    end else begin
      unique case (st_q)
        ST_SLEEP, ST_HOLD: begin
          st_d  = ST_RAMP;
          lvl_d = '0;
        end
        ST_STOP: begin
          if (lvl_q < OFF_V) begin
            st_d  = ST_RAMP;
            lvl_d = '0;
          end else begin
            lvl_d = dn_nxt;
          end
        end
        ST_RAMP, ST_RUN: begin
          if (oc_trip) begin
            st_d  = ST_STOP;
            lvl_d = dn_nxt;
          end else begin
            lvl_d = up_nxt;
            st_d  = (up_nxt == max_lvl) ? ST_RUN : ST_RAMP;
          end
        end
        default: begin
          st_d  = ST_SLEEP;
          lvl_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SLEEP;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign state = st_q;
  assign level = lvl_q;
endmodule

// File: rtl/ss_cmd_clamp.sv
module ss_cmd_clamp #(
  parameter int LVL_W = 8
) (
  input  logic             pass_all,
  input  logic [LVL_W-1:0] limit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LVL_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LVL_W-1:0] out_data
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = (pass_all || (in_data <= limit)) ? in_data : limit;
endmodule

// File: rtl/ss_fault_seq.sv
module ss_fault_seq
  import ss_seq_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int SUP_W = 8,
  parameter int STEP_W = 4,
  parameter int UV_START_CODE = 176,
  parameter int UV_STOP_CODE = 144,
  parameter int OFF_LVL = 16,
  parameter int DOWN_MUL = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_off,
  input  logic [SUP_W-1:0]  supply_code,
  input  logic              ref_ok,
  input  logic              oc_trip,
  input  logic              peak_trip,
  input  logic [STEP_W-1:0] cfg_up_step,
  input  logic [LVL_W-1:0]  cfg_max_lvl,
  input  logic              cmd_in_valid,
  output logic              cmd_in_ready,
  input  logic [LVL_W-1:0]  cmd_in_data,
  output logic              cmd_out_valid,
  input  logic              cmd_out_ready,
  output logic [LVL_W-1:0]  cmd_out_data,
  output logic [LVL_W-1:0]  ss_level,
  output logic              out_en,
  output logic              cyc_limit,
  output logic [2:0]        state_code
);
  localparam logic [LVL_W-1:0] OFF_V = LVL_W'(OFF_LVL);

  logic      uv_now;
  ss_state_e st;

  ss_uv_hyst #(
    .SUP_W(SUP_W), .START_CODE(UV_START_CODE), .STOP_CODE(UV_STOP_CODE)
  ) u_uv (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .uv_now(uv_now)
  );

  ss_level_fsm #(
    .LVL_W(LVL_W), .STEP_W(STEP_W), .OFF_LVL(OFF_LVL), .DOWN_MUL(DOWN_MUL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .uv_now(uv_now), .ref_ok(ref_ok),
    .ext_off(ext_off), .oc_trip(oc_trip), .up_step(cfg_up_step),
    .max_lvl(cfg_max_lvl), .state(st), .level(ss_level)
  );

  ss_cmd_clamp #(.LVL_W(LVL_W)) u_clamp (
    .pass_all(st == ST_RUN), .limit(ss_level),
    .in_valid(cmd_in_valid), .in_ready(cmd_in_ready), .in_data(cmd_in_data),
    .out_valid(cmd_out_valid), .out_ready(cmd_out_ready), .out_data(cmd_out_data)
  );

  assign out_en = (ss_level > OFF_V) && ((st == ST_RAMP) || (st == ST_RUN)) &&
                  !uv_now && ref_ok && !ext_off && !oc_trip;
  assign cyc_limit  = peak_trip && out_en;
  assign state_code = st;
endmodule

// File: rtl/ss_fault_seq_chk.sv
module ss_fault_seq_chk #(
  parameter int LVL_W = 8,
  parameter int SUP_W = 8,
  parameter int STEP_W = 4,
  parameter int UV_START_CODE = 176,
  parameter int UV_STOP_CODE = 144,
  parameter int OFF_LVL = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_off,
  input logic [SUP_W-1:0]  supply_code,
  input logic              ref_ok,
  input logic              oc_trip,
  input logic [STEP_W-1:0] cfg_up_step,
  input logic [LVL_W-1:0]  cfg_max_lvl,
  input logic [LVL_W-1:0]  cmd_out_data,
  input logic [LVL_W-1:0]  ss_level,
  input logic              out_en,
  input logic              cyc_limit,
  input logic [2:0]        state_code
);
  localparam logic [SUP_W-1:0] STOP_V  = SUP_W'(UV_STOP_CODE);
  localparam logic [SUP_W-1:0] START_V = SUP_W'(UV_START_CODE);
  localparam logic [LVL_W-1:0] OFF_V   = LVL_W'(OFF_LVL);

  p_uv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok || supply_code < STOP_V) |=> (ss_level == '0 && state_code == 3'd0));

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_off |=> ss_level == '0);

  p_oe_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (ss_level > OFF_V && !oc_trip && !ext_off && ref_ok && supply_code >= STOP_V));

  p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd2) |-> cmd_out_data <= ss_level);

  p_run_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && $stable(cfg_max_lvl)) |-> ss_level == cfg_max_lvl);

  p_stop_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd3 && ss_level >= OFF_V && cfg_up_step != '0 && ref_ok &&
     supply_code >= START_V && !ext_off) |=> ss_level < $past(ss_level));

  p_peak_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_limit |-> out_en);
endmodule

bind ss_fault_seq ss_fault_seq_chk #(
  .LVL_W(LVL_W), .SUP_W(SUP_W), .STEP_W(STEP_W),
  .UV_START_CODE(UV_START_CODE), .UV_STOP_CODE(UV_STOP_CODE), .OFF_LVL(OFF_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_off(ext_off), .supply_code(supply_code),
  .ref_ok(ref_ok), .oc_trip(oc_trip), .cfg_up_step(cfg_up_step),
  .cfg_max_lvl(cfg_max_lvl), .cmd_out_data(cmd_out_data), .ss_level(ss_level),
  .out_en(out_en), .cyc_limit(cyc_limit), .state_code(state_code)
);

// File: tb/tb_ss_fault_seq.sv
`timescale 1ns/1ps
module tb_ss_fault_seq;
  localparam int START = 176, STOP = 144, OFF = 16, MUL = 10;

  logic clk = 0, rst_n = 0;
  logic ext_off = 0, ref_ok = 1, oc_trip = 0, peak_trip = 0;
  logic [7:0] supply_code = 0, cfg_max_lvl = 0, cmd_in_data = 0;
  logic [3:0] cfg_up_step = 0;
  logic cmd_in_valid = 0, cmd_out_ready = 0;
  logic cmd_in_ready, cmd_out_valid, out_en, cyc_limit;
  logic [7:0] cmd_out_data, ss_level;
  logic [2:0] state_code;

  int n_vec = 0, n_bad = 0;
  int m_st = 0, m_lvl = 0, m_uvf = 1;
  bit done = 0;

  always #10 clk = ~clk;

  ss_fault_seq dut (
    .clk(clk), .rst_n(rst_n), .ext_off(ext_off), .supply_code(supply_code),
    .ref_ok(ref_ok), .oc_trip(oc_trip), .peak_trip(peak_trip),
    .cfg_up_step(cfg_up_step), .cfg_max_lvl(cfg_max_lvl),
    .cmd_in_valid(cmd_in_valid), .cmd_in_ready(cmd_in_ready),
    .cmd_in_data(cmd_in_data), .cmd_out_valid(cmd_out_valid),
    .cmd_out_ready(cmd_out_ready), .cmd_out_data(cmd_out_data),
    .ss_level(ss_level), .out_en(out_en), .cyc_limit(cyc_limit),
    .state_code(state_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: inputs already driven after a negedge.
  task automatic step();
    int uvn, e_oe, e_cmd, n_st, n_lvl, dn, up;
    string tag;
    #1;
    uvn = (supply_code < STOP) || (m_uvf && supply_code < START);
    e_oe = (m_lvl > OFF) && (m_st == 1 || m_st == 2) && !uvn && ref_ok && !ext_off && !oc_trip;
    e_cmd = (m_st == 2 || cmd_in_data <= m_lvl) ? int'(cmd_in_data) : m_lvl;
    chk(out_en == e_oe, "R8 out_en", out_en, e_oe);
    chk(cyc_limit == (peak_trip && e_oe), "R9 cyc_limit", cyc_limit, peak_trip && e_oe);
    chk(cmd_out_data == e_cmd, "R6 clamp", cmd_out_data, e_cmd);
    chk(cmd_out_valid == cmd_in_valid && cmd_in_ready == cmd_out_ready, "R10 stream",
        {cmd_out_valid, cmd_in_ready}, {cmd_in_valid, cmd_out_ready});
    dn = MUL * int'(cfg_up_step);
    up = m_lvl + int'(cfg_up_step);
    if (up > cfg_max_lvl) up = cfg_max_lvl;
    n_st = m_st; n_lvl = m_lvl;
    if (uvn || !ref_ok) begin n_st = 0; n_lvl = 0; tag = "R3"; end
    else if (ext_off) begin n_st = 4; n_lvl = 0; tag = "R7"; end
    else if (m_st == 0 || m_st == 4) begin n_st = 1; n_lvl = 0; tag = "R5"; end
    else if (m_st == 3) begin
      tag = "R4";
      if (m_lvl < OFF) begin n_st = 1; n_lvl = 0; end
      else n_lvl = (m_lvl > dn) ? m_lvl - dn : 0;
    end else if (oc_trip) begin
      tag = "R4"; n_st = 3; n_lvl = (m_lvl > dn) ? m_lvl - dn : 0;
    end else begin
      tag = "R5"; n_lvl = up; n_st = (up == cfg_max_lvl) ? 2 : 1;
    end
    if (supply_code >= STOP && supply_code < START) tag = {tag, "/R2"};
    m_uvf = uvn; m_st = n_st; m_lvl = n_lvl;
    @(posedge clk); #1;
    chk(ss_level == m_lvl, {tag, " level"}, ss_level, m_lvl);
    chk(state_code == m_st, {tag, " state"}, state_code, m_st);
    @(negedge clk);
  endtask

  task automatic drive(input int i);
    peak_trip = (i % 3) == 0;
    cmd_in_data = 8'((i * 37) & 8'hFF);
    cmd_in_valid = (i % 4) != 1;
    cmd_out_ready = (i % 2) == 0;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) begin drive(i); step(); end
  endtask

  task automatic run_to_run(input int lim);
    for (int i = 0; i < lim && m_st != 2; i++) begin drive(i); step(); end
    chk(m_st == 2 && state_code == 3'd2, "R5 reached run", state_code, 2);
  endtask

  initial begin
    int steps[3] = '{1, 3, 7};
    int maxes[3] = '{40, 200, 255};
    foreach (steps[a]) foreach (maxes[b]) begin
      @(negedge clk);
      rst_n = 0; ext_off = 0; ref_ok = 1; oc_trip = 0; supply_code = 0;
      cfg_up_step = 4'(steps[a]); cfg_max_lvl = 8'(maxes[b]);
      m_st = 0; m_lvl = 0; m_uvf = 1;
      @(negedge clk); #1;
      chk(state_code == 0 && ss_level == 0 && out_en == 0, "R1 reset",
          {state_code, ss_level, out_en}, 0);
      rst_n = 1;
      @(negedge clk);
      run_n(3);                    // deep undervoltage
      supply_code = 160; run_n(3); // inside band: R2 stays in sleep
      chk(state_code == 0, "R2 band keeps fault", state_code, 0);
      supply_code = 200;
      run_to_run(300);
      run_n(5);
      supply_code = 150; run_n(4); // band after clear: R2 keeps running
      chk(state_code == 2, "R2 band keeps run", state_code, 2);
      supply_code = 200;
      oc_trip = 1; run_n(2); oc_trip = 0;
      run_to_run(400);
      oc_trip = 1; supply_code = 100; run_n(1); // concurrent: R3 wins over R4
      chk(state_code == 0 && ss_level == 0, "R3 beats overcurrent", state_code, 0);
      oc_trip = 0; supply_code = 200; run_n(10);
      ext_off = 1; run_n(3); ext_off = 0;
      run_n(8);
      ref_ok = 0; run_n(2); ref_ok = 1;
      run_to_run(300);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule